// File: doc/BRIEF.md
# Outbound Memory Address Translation Windows

This block sits between a local processor bus and a 64-bit PCI memory space. It holds a small set of programmable windows. Each window takes a naturally sized slice of the 32-bit local address space and relocates it to any 64-bit PCI memory address. Software programs every window through a simple register port. A window has four 32-bit words: the local base, the low and high halves of the PCI target address, and a mask word. The mask word encodes the window size as a run of high-order ones. Its two lowest bits carry the enable flag and the prefetchable attribute.

For each outbound request the block compares the local address against all enabled windows in parallel. The lowest-numbered matching window wins. The block returns the translated PCI address, a hit flag, the index of the winning window and its prefetchable attribute, all in the same cycle as the request. A request that matches nothing raises an address-error flag and drives the other result outputs to zero. A generate-time option chooses between one shared translation adder placed after window selection and one adder per window placed ahead of the selection mux.

Top module: `obx_xlate`

## Requirements
- R1: There are NUM_WIN windows (default 3). Window j owns byte offsets 0x10*j to 0x10*j+0xC. Word 0x0 is the local base, 0x4 the PCI target low word, 0x8 the PCI target high word and 0xC the mask/attribute word. cfg_addr[1:0] are ignored, and a read returns the stored 32-bit value unchanged.
- R2: A write with cfg_we high is captured on the rising clock edge. It is visible on cfg_rdata and in lookups from that edge on, and it is not visible before that edge.
- R3: Offsets whose window field (cfg_addr[AW-1:4]) is NUM_WIN or higher read as zero, and writes to them change nothing.
- R4: After reset every register reads zero and no request hits.
- R5: A window takes part in matching only while bit 0 of its mask word is 1. With bit 0 at 0 it never matches, whatever its other bits hold.
- R6: An enabled window matches when (req_addr & M) equals (base & M), where M is the mask word with bits [11:0] cleared. Mask bits [11:2] have no effect.
- R7: When several windows match, the lowest-numbered one is reported.
- R8: The translated address is {high word, low word} + zero-extended (req_addr - base) mod 2^32. A carry out of the low word propagates into the high word.
- R9: out_pref equals bit 1 of the winning window's mask word.
- R10: With req_valid high and no match, out_err is 1 and out_hit is 0. With req_valid low, both flags are 0. Whenever out_hit is 0, out_win, out_pref and out_pci_addr are all zero.
- R11: The lookup is combinational. Results follow req_addr and req_valid within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | AW (6) | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr |
| req_valid | input | 1 | Outbound request present |
| req_addr | input | LA_W (32) | Local address of the request |
| out_hit | output | 1 | Request matched a window |
| out_err | output | 1 | Valid request matched no window |
| out_win | output | IW (2) | Index of the winning window |
| out_pref | output | 1 | Winning window is prefetchable |
| out_pci_addr | output | PA_W (64) | Translated PCI memory address |

## Verification
The assertions check several properties on every cycle. The hit and error flags must be mutually exclusive and follow req_valid. A miss must zero all result fields, and a reported index must never exceed the window count. A mapped write must show on the read port in the next cycle, unmapped offsets must read zero, and nothing may hit before the first register write after reset. Other behaviours only the bench's scenarios can show: the address arithmetic (low-word carry, offset from the base), lowest-index priority among overlapping windows, the 4 GiB catch-all window, masks with junk low bits, and windows disabled by a clear enable bit. To cover them, the bench sweeps thousands of addresses over several window layouts and checks each against its own model.

// File: rtl/obx_pkg.sv
package obx_pkg;
   localparam int REG_W = 32;
   localparam int WIN_STRIDE_SH = 4;
   localparam logic [1:0] W_LBASE = 2'd0;
   localparam logic [1:0] W_PLO   = 2'd1;
   localparam logic [1:0] W_PHI   = 2'd2;
   localparam logic [1:0] W_MASK  = 2'd3;
   localparam int FLAG_EN   = 0;
   localparam int FLAG_PREF = 1;

   typedef struct packed {
      logic [REG_W-1:0] lbase;
      logic [REG_W-1:0] plo;
      logic [REG_W-1:0] phi;
      logic [REG_W-1:0] mattr;
   } win_cfg_t;
endpackage

// File: rtl/obx_win_regs.sv
module obx_win_regs
   import obx_pkg::*;
#(
   parameter int NUM_WIN = 3,
   parameter int AW      = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [AW-1:0]    addr,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] rdata,
   output win_cfg_t         cfg [NUM_WIN]
);
   localparam int IW = AW - WIN_STRIDE_SH;

   logic [IW-1:0] sel_win;
   logic [1:0]    sel_word;
   logic [1:0]    unused_byte;

   assign sel_win     = addr[AW-1:WIN_STRIDE_SH];
   assign sel_word    = addr[3:2];
   assign unused_byte = addr[1:0];

   generate
      for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
         logic [REG_W-1:0] lb_q, lo_q, hi_q, ma_q;
         logic             hit_w;

         assign hit_w = we && (sel_win == IW'(g));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               lb_q <= '0;
               lo_q <= '0;
               hi_q <= '0;
               ma_q <= '0;
            end else if (hit_w) begin
               case (sel_word)
                  W_LBASE: lb_q <= wdata;
                  W_PLO:   lo_q <= wdata;
                  W_PHI:   hi_q <= wdata;
                  default: ma_q <= wdata;
               endcase
            end
         end

         assign cfg[g] = {lb_q, lo_q, hi_q, ma_q};
      end
   endgenerate

   always_comb begin
      rdata = '0;
      for (int i = 0; i < NUM_WIN; i++) begin
         if (sel_win == IW'(i)) begin
            case (sel_word)
               W_LBASE: rdata = cfg[i].lbase;
               W_PLO:   rdata = cfg[i].plo;
               W_PHI:   rdata = cfg[i].phi;
               default: rdata = cfg[i].mattr;
            endcase
         end
      end
   end
endmodule

// File: rtl/obx_win_match.sv
module obx_win_match
   import obx_pkg::*;
#(
   parameter int PAGE_SHIFT = 12
) (
   input  logic [REG_W-1:0] lbase,
   input  logic [REG_W-1:0] mattr,
   input  logic [REG_W-1:0] laddr,
   output logic             hit
);
   localparam logic [REG_W-1:0] PAGE_KEEP = {REG_W{1'b1}} << PAGE_SHIFT;

   logic [REG_W-1:0] cmp_mask;
   logic             unused_low;

   assign cmp_mask   = mattr & PAGE_KEEP;
   assign hit        = mattr[FLAG_EN] && ((laddr & cmp_mask) == (lbase & cmp_mask));
   assign unused_low = ^{mattr[PAGE_SHIFT-1:1], lbase[PAGE_SHIFT-1:0], laddr[PAGE_SHIFT-1:0]};
endmodule

// File: rtl/obx_win_pick.sv
module obx_win_pick #(
   parameter int NUM_WIN = 3,
   parameter int IW      = 2
) (
   input  logic [NUM_WIN-1:0] hits,
   output logic               any,
   output logic [IW-1:0]      idx
);
   assign any = |hits;

   always_comb begin
      idx = '0;
      for (int i = NUM_WIN - 1; i >= 0; i--) begin
         if (hits[i]) idx = IW'(i);
      end
   end
endmodule

// File: rtl/obx_xlate_add.sv
module obx_xlate_add
   import obx_pkg::*;
#(
   parameter int PA_W = 64
) (
   input  logic [REG_W-1:0] laddr,
   input  logic [REG_W-1:0] lbase,
   input  logic [REG_W-1:0] plo,
   input  logic [REG_W-1:0] phi,
   output logic [PA_W-1:0]  pci
);
   logic [REG_W-1:0] offs;

   assign offs = laddr - lbase;
   assign pci  = {phi, plo} + {{(PA_W-REG_W){1'b0}}, offs};
endmodule

// File: rtl/obx_xlate.sv
module obx_xlate
   import obx_pkg::*;
#(
   parameter int NUM_WIN    = 3,
   parameter int LA_W       = 32,
   parameter int PA_W       = 64,
   parameter int PAGE_SHIFT = 12,
   parameter bit SHARED_ADD = 1'b1,
   localparam int IW = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1,
   localparam int AW = IW + WIN_STRIDE_SH
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [AW-1:0]    cfg_addr,
   input  logic [REG_W-1:0] cfg_wdata,
   output logic [REG_W-1:0] cfg_rdata,
   input  logic             req_valid,
   input  logic [LA_W-1:0]  req_addr,
   output logic             out_hit,
   output logic             out_err,
   output logic [IW-1:0]    out_win,
   output logic             out_pref,
   output logic [PA_W-1:0]  out_pci_addr
);
   generate
      if (NUM_WIN < 1 || NUM_WIN > 16) begin : g_bad_num
         $error("obx_xlate: NUM_WIN must lie in 1..16");
      end
      if (LA_W != REG_W) begin : g_bad_la
         $error("obx_xlate: LA_W must equal the register width");
      end
      if (PA_W != 2 * REG_W) begin : g_bad_pa
         $error("obx_xlate: PA_W must be twice the register width");
      end
      if (PAGE_SHIFT < 3 || PAGE_SHIFT > 31) begin : g_bad_page
         $error("obx_xlate: PAGE_SHIFT must lie in 3..31");
      end
   endgenerate

   win_cfg_t         cfg [NUM_WIN];
   logic [NUM_WIN-1:0] hits;
   logic             any_hit;
   logic [IW-1:0]    win_idx;
   win_cfg_t         sel_cfg;
   logic [PA_W-1:0]  sel_pci;
   logic             unused_attr;

   obx_win_regs #(
      .NUM_WIN (NUM_WIN),
      .AW      (AW)
   ) u_regs (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (cfg_we),
      .addr  (cfg_addr),
      .wdata (cfg_wdata),
      .rdata (cfg_rdata),
      .cfg   (cfg)
   );

   generate
      for (genvar g = 0; g < NUM_WIN; g++) begin : g_match
         obx_win_match #(
            .PAGE_SHIFT (PAGE_SHIFT)
         ) u_match (
            .lbase (cfg[g].lbase),
            .mattr (cfg[g].mattr),
            .laddr (req_addr),
            .hit   (hits[g])
         );
      end
   endgenerate

   obx_win_pick #(
      .NUM_WIN (NUM_WIN),
      .IW      (IW)
   ) u_pick (
      .hits (hits),
      .any  (any_hit),
      .idx  (win_idx)
   );

   always_comb begin
      sel_cfg = '0;
      for (int i = 0; i < NUM_WIN; i++) begin
         if (win_idx == IW'(i)) sel_cfg = cfg[i];
      end
   end

   assign unused_attr = ^{sel_cfg.mattr[REG_W-1:2], sel_cfg.mattr[FLAG_EN]};

   generate
      if (SHARED_ADD) begin : g_shared
         obx_xlate_add #(
            .PA_W (PA_W)
         ) u_add (
            .laddr (req_addr),
            .lbase (sel_cfg.lbase),
            .plo   (sel_cfg.plo),
            .phi   (sel_cfg.phi),
            .pci   (sel_pci)
         );
      end else begin : g_per_win
         logic [PA_W-1:0] win_pci [NUM_WIN];
         for (genvar g = 0; g < NUM_WIN; g++) begin : g_add
            obx_xlate_add #(
               .PA_W (PA_W)
            ) u_add (
               .laddr (req_addr),
               .lbase (cfg[g].lbase),
               .plo   (cfg[g].plo),
               .phi   (cfg[g].phi),
               .pci   (win_pci[g])
            );
         end
         always_comb begin
            sel_pci = '0;
            for (int i = 0; i < NUM_WIN; i++) begin
               if (win_idx == IW'(i)) sel_pci = win_pci[i];
            end
         end
      end
   endgenerate

   assign out_hit      = req_valid && any_hit;
   assign out_err      = req_valid && !any_hit;
   assign out_win      = out_hit ? win_idx : '0;
   assign out_pref     = out_hit && sel_cfg.mattr[FLAG_PREF];
   assign out_pci_addr = out_hit ? sel_pci : '0;
endmodule

// File: rtl/obx_xlate_chk.sv
module obx_xlate_chk #(
   parameter int NUM_WIN = 3,
   parameter int IW      = 2,
   parameter int AW      = 6,
   parameter int LA_W    = 32,
   parameter int PA_W    = 64
) (
   input logic            clk,
   input logic            rst_n,
   input logic            cfg_we,
   input logic [AW-1:0]   cfg_addr,
   input logic [31:0]     cfg_wdata,
   input logic [31:0]     cfg_rdata,
   input logic            req_valid,
   input logic [LA_W-1:0] req_addr,
   input logic            out_hit,
   input logic            out_err,
   input logic [IW-1:0]   out_win,
   input logic            out_pref,
   input logic [PA_W-1:0] out_pci_addr
);
   logic wr_seen;
   logic mapped;
   logic unused_req;

   assign mapped     = int'(cfg_addr[AW-1:4]) < NUM_WIN;
   assign unused_req = ^req_addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wr_seen <= 1'b0;
      else if (cfg_we) wr_seen <= 1'b1;
   end

   a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (out_hit != out_err));

   a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |-> (!out_hit && !out_err));

   a_r10_miss_zeroed: assert property (@(posedge clk) disable iff (!rst_n)
      !out_hit |-> (out_pci_addr == '0 && out_win == '0 && !out_pref));

   a_r1_index_range: assert property (@(posedge clk) disable iff (!rst_n)
      out_hit |-> (int'(out_win) < NUM_WIN));

   a_r2_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && mapped) |=> ((cfg_addr[AW-1:2] != $past(cfg_addr[AW-1:2])) ||
                              (cfg_rdata == $past(cfg_wdata))));

   a_r3_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !mapped |-> (cfg_rdata == '0));

   a_r4_no_hit_before_write: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_seen |-> !out_hit);
endmodule

bind obx_xlate obx_xlate_chk #(
   .NUM_WIN (NUM_WIN),
   .IW      (IW),
   .AW      (AW),
   .LA_W    (LA_W),
   .PA_W    (PA_W)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cfg_we       (cfg_we),
   .cfg_addr     (cfg_addr),
   .cfg_wdata    (cfg_wdata),
   .cfg_rdata    (cfg_rdata),
   .req_valid    (req_valid),
   .req_addr     (req_addr),
   .out_hit      (out_hit),
   .out_err      (out_err),
   .out_win      (out_win),
   .out_pref     (out_pref),
   .out_pci_addr (out_pci_addr)
);

// File: tb/sim_obx_xlate.sv
`timescale 1ns/1ps
module sim_obx_xlate;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [5:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        req_valid = 1'b0;
   logic [31:0] req_addr = '0;
   logic        out_hit, out_err, out_pref;
   logic [1:0]  out_win;
   logic [63:0] out_pci_addr;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 1'b0;

   logic [31:0] m_base [3];
   logic [31:0] m_lo   [3];
   logic [31:0] m_hi   [3];
   logic [31:0] m_ma   [3];

   always #5 clk = ~clk;

   obx_xlate u0 (
      .clk (clk), .rst_n (rst_n),
      .cfg_we (cfg_we), .cfg_addr (cfg_addr), .cfg_wdata (cfg_wdata), .cfg_rdata (cfg_rdata),
      .req_valid (req_valid), .req_addr (req_addr),
      .out_hit (out_hit), .out_err (out_err), .out_win (out_win),
      .out_pref (out_pref), .out_pci_addr (out_pci_addr)
   );

   task automatic model_put(input logic [5:0] a, input logic [31:0] d);
      int w;
      w = int'(a[5:4]);
      if (w < 3) begin
         case (a[3:2])
            2'd0: m_base[w] = d;
            2'd1: m_lo[w]   = d;
            2'd2: m_hi[w]   = d;
            default: m_ma[w] = d;
         endcase
      end
   endtask

   function automatic logic [31:0] model_get(input logic [5:0] a);
      int w;
      w = int'(a[5:4]);
      if (w >= 3) return 32'h0;
      case (a[3:2])
         2'd0: return m_base[w];
         2'd1: return m_lo[w];
         2'd2: return m_hi[w];
         default: return m_ma[w];
      endcase
   endfunction

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
      model_put(a, d);
   endtask

   task automatic rd_check(input logic [5:0] a, input logic [31:0] exp, input string tag);
      cfg_addr = a;
      #1;
      n_vec++;
      if (cfg_rdata !== exp) begin
         n_bad++;
         $display("FAIL %s: reg 0x%02h read 0x%08h expected 0x%08h", tag, a, cfg_rdata, exp);
      end
   endtask

   task automatic look(input logic [31:0] a, input logic v, input string tag);
      logic        eh, ee, ep;
      logic [1:0]  ew;
      logic [63:0] epa;
      logic [31:0] m;
      eh = 1'b0; ee = v; ep = 1'b0; ew = 2'd0; epa = 64'd0;
      if (v) begin
         for (int j = 2; j >= 0; j--) begin
            m = m_ma[j] & 32'hFFFF_F000;
            if (m_ma[j][0] && ((a & m) == (m_base[j] & m))) begin
               eh = 1'b1; ee = 1'b0; ew = 2'(j); ep = m_ma[j][1];
               epa = {m_hi[j], m_lo[j]} + {32'd0, a - m_base[j]};
            end
         end
      end
      req_addr = a; req_valid = v;
      #1;
      n_vec++;
      if (out_hit !== eh || out_err !== ee || out_win !== ew || out_pref !== ep || out_pci_addr !== epa) begin
         n_bad++;
         $display("FAIL %s: addr 0x%08h v=%0b got hit=%0b err=%0b win=%0d pref=%0b pci=0x%016h expected hit=%0b err=%0b win=%0d pref=%0b pci=0x%016h",
                  tag, a, v, out_hit, out_err, out_win, out_pref, out_pci_addr, eh, ee, ew, ep, epa);
      end
   endtask

   task automatic sweep(input string tag);
      logic [31:0] a;
      for (int k = 0; k < 4096; k++) begin
         a = {k[11:0], 20'h0} | ((k * 32'h0001_3579) & 32'h000F_FFFF);
         look(a, 1'b1, tag);
      end
      for (int k = 0; k < 288; k++) begin
         a = 32'h3FFF_0000 + k * 32'h1000 + ((k * 32'h123) & 32'hFFF);
         look(a, 1'b1, tag);
      end
      for (int k = 0; k < 16; k++) begin
         look(32'h4008_0000 + k * 32'h100 + 32'hFF, 1'b1, tag);
      end
   endtask

   initial begin
      for (int j = 0; j < 3; j++) begin
         m_base[j] = '0; m_lo[j] = '0; m_hi[j] = '0; m_ma[j] = '0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R4: reset values and no hit
      for (int r = 0; r < 16; r++) rd_check(6'(r * 4), 32'h0, "R4 reset reg");
      look(32'h0000_0000, 1'b1, "R4 reset miss");
      look(32'hFFFF_F000, 1'b1, "R4 reset miss");

      // R1: program the three windows
      wr(6'h00, 32'h4000_0000);
      wr(6'h04, 32'h2000_0000);
      wr(6'h08, 32'h0000_0001);
      wr(6'h10, 32'h4008_0000);
      wr(6'h14, 32'hFFFF_F800);
      wr(6'h18, 32'h0000_0005);
      wr(6'h1C, 32'hFFFF_F001);
      wr(6'h20, 32'h9000_0000);
      wr(6'h24, 32'h1111_0000);
      wr(6'h28, 32'h0000_000A);
      wr(6'h2C, 32'h0000_0FFE);   // R5: enable clear, other bits set

      // R2: mask write not visible before the edge, visible after
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = 6'h0C; cfg_wdata = 32'hFFF0_0FF3;
      #1;
      n_vec++;
      if (cfg_rdata !== 32'h0) begin
         n_bad++;
         $display("FAIL R2: early read 0x%08h expected 0x00000000", cfg_rdata);
      end
      look(32'h4000_1234, 1'b1, "R2 before edge");
      @(negedge clk);
      cfg_we = 1'b0;
      model_put(6'h0C, 32'hFFF0_0FF3);
      rd_check(6'h0C, 32'hFFF0_0FF3, "R2 after edge");
      look(32'h4000_1234, 1'b1, "R2 after edge");

      // R1: readback of every register, ignoring byte lane bits
      for (int r = 0; r < 12; r++) rd_check(6'(r * 4), model_get(6'(r * 4)), "R1 readback");
      rd_check(6'h07, 32'h2000_0000, "R1 byte bits ignored");

      // R3: unmapped offsets
      wr(6'h30, 32'hDEAD_BEEF);
      wr(6'h3C, 32'hFFFF_FFFF);
      rd_check(6'h30, 32'h0, "R3 unmapped read");
      rd_check(6'h3C, 32'h0, "R3 unmapped read");
      look(32'h1234_5000, 1'b1, "R3 write had no effect");

      // R6 R7 R9 R5: w0 covers w1, w2 disabled
      look(32'h4008_0010, 1'b1, "R7 overlap lowest wins");
      look(32'h4000_0000, 1'b1, "R6 window base");
      look(32'h400F_FFFF, 1'b1, "R6 window top");
      look(32'h4010_0000, 1'b1, "R10 just above");
      look(32'h9000_0000, 1'b1, "R5 disabled window");
      sweep("R6 phase A");

      // R10: idle request
      look(32'h4000_0100, 1'b0, "R10 idle");
      look(32'h9000_0000, 1'b0, "R10 idle");

      // R8: disable w0, w1 now wins, carry into high word
      wr(6'h0C, 32'h0000_0000);
      look(32'h4008_07FF, 1'b1, "R8 no carry");
      look(32'h4008_0800, 1'b1, "R8 carry");
      look(32'h4008_0FFF, 1'b1, "R8 carry top");
      sweep("R8 phase B");

      // R9 R7: w2 as a prefetchable catch-all, w0 back on
      wr(6'h2C, 32'h0000_0003);
      wr(6'h0C, 32'hFFF0_0001);
      look(32'h0000_0000, 1'b1, "R9 catch-all low");
      look(32'hFFFF_FFFF, 1'b1, "R9 catch-all high");
      look(32'h4008_0004, 1'b1, "R7 three overlap");
      sweep("R11 phase C");

      // R4: reset again clears every window
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      rst_n = 1'b1;
      for (int j = 0; j < 3; j++) begin
         m_base[j] = '0; m_lo[j] = '0; m_hi[j] = '0; m_ma[j] = '0;
      end
      look(32'h4000_0000, 1'b1, "R4 after re-reset");
      rd_check(6'h2C, 32'h0, "R4 after re-reset");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      #1_500_000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not finish, got hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule